// File: doc/BRIEF.md
# Cyclic Channel Transfer Sequencer

This block is the engine of one streaming DMA channel. Software queues transfer descriptors, each a byte length and a notify bit, into a four-slot submission ring. While the channel is running, the block takes the oldest descriptor and moves its bytes into a channel FIFO. Memory traffic uses a byte-count request and acknowledge handshake, and a peripheral removes the data one word at a time. The residue output shows how many bytes of the active descriptor are still to be requested. It jumps up to the new length when the next descriptor is taken, so a reader comparing two samples can see that a load happened.

Every finished descriptor produces a four-word completion report in a second four-slot ring. Software drains each report with four consecutive reads from one read port. The block also holds the word-size and words-per-frame setting and the FIFO occupancy limit and request threshold. It tells the peripheral side the position of each word within its frame.

Top module: `cyclic_xfer_seq`

## Requirements
- R1: While a descriptor is active, each acknowledged request lowers `residue` by `mem_bytes` at that clock edge.
- R2: At the edge where the last byte of a descriptor is acknowledged, the next descriptor is loaded at that same edge if the submission ring holds one. `residue` then shows its full length, which may be higher than before. If the ring is empty, `residue` becomes 0 and no request is raised.
- R3: `mem_req` is raised only when the channel is running, a descriptor is active and the FIFO level is at or below the threshold. `mem_bytes` is the smaller of `residue` and the free room (limit minus level), so the level never exceeds the limit.
- R4: While `run` is low, no request is raised and no descriptor is loaded. The ring contents, `residue` and FIFO level are kept, and the transfer continues when `run` returns high.
- R5: Both ring status outputs use this layout: write slot in bits 1:0, read slot in bits 5:4, empty in bit 8, full in bit 9, sticky error in bit 10. All other bits are 0.
- R6: `rpt_rdata` presents the words of the oldest report in this order: count low, count high, a zero word, then flags (bit 0 = notify). Each `rpt_rd` advances to the next word, and the fourth read removes the report. A read while the ring is empty returns 0 and changes nothing.
- R7: The report count is the channel's running 64-bit byte total since reset, including the finished descriptor.
- R8: A report produced while the report ring is full is dropped, and report error bit 10 is set and stays set. If the fourth read of a report happens at the same edge, the ring has room and the report is stored.
- R9: `desc_done` is high for the cycle after the finishing edge, and only if the finished descriptor had its notify bit set.
- R10: A descriptor push is accepted when the submission ring is not full, or when a descriptor is taken at the same edge. Otherwise it is ignored and submission error bit 10 is set. Pushes of length 0 are ignored.
- R11: Writing the word-size register sets the word size from bits 1:0: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes. `per_avail` is high when the FIFO level is at least one word. An accepted `per_take` removes one word.
- R12: Bits 5:4 of the same register set the words per frame: 0 gives 1 word, 1 gives 2 words, 2 gives 4 words. `per_pos` gives the position of the presented word, advances on every accepted take, wraps after the last word, and returns to 0 when the register is written.
- R13: The FIFO control write takes the limit from bits 31:16 and the threshold from bits 15:0, both in bytes. After reset the limit is 64 and the threshold is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel started when high, halted when low |
| desc_push | input | 1 | Queue one descriptor |
| desc_len | input | LEN_W | Descriptor byte length |
| desc_notify | input | 1 | Descriptor asks for a done pulse |
| sub_status | output | 11 | Submission ring status |
| cfg_bw_we | input | 1 | Write word-size and frame register |
| cfg_fifo_we | input | 1 | Write FIFO limit and threshold |
| cfg_wdata | input | 32 | Configuration write data |
| mem_req | output | 1 | Memory burst request |
| mem_bytes | output | LIM_W | Bytes asked for in the burst |
| mem_ack | input | 1 | Burst granted in full this cycle |
| per_avail | output | 1 | At least one word in the FIFO |
| per_take | input | 1 | Peripheral removes one word |
| per_pos | output | 2 | Position of the presented word in its frame |
| fifo_level | output | LIM_W | FIFO occupancy in bytes |
| residue | output | LEN_W | Bytes left in the active descriptor |
| rpt_rd | input | 1 | Read one report word |
| rpt_rdata | output | 32 | Current report word |
| rpt_status | output | 11 | Report ring status |
| desc_done | output | 1 | Notify-descriptor finished pulse |

## Verification
Two functions can act at the same edge. The last acknowledged burst of a descriptor pushes a report, and a software read can retire the oldest report at that edge. The bench fills the report ring, holds the request of one more descriptor without acknowledging it, and issues three report reads. It then asserts the fourth read and the acknowledge in the same cycle. It expects the ring to show full with advanced read and write slots and no error. It then forces a second completion against a full ring with no read, and expects the error bit while the oldest stored total is unchanged. A constrained-random phase mixes acknowledges, word takes and report reads across word sizes and frame lengths, and compares every report word with totals computed from the queued lengths.

// File: rtl/cxs_pkg.sv
package cxs_pkg;
   localparam int ST_W = 11;

   // ring status word: err(10) full(9) empty(8) rd slot(5:4) wr slot(1:0)
   function automatic logic [ST_W-1:0] pack_status(input logic [1:0] wr_slot,
                                                   input logic [1:0] rd_slot,
                                                   input logic       empty,
                                                   input logic       full,
                                                   input logic       err);
      return {err, full, empty, 2'b00, rd_slot, 2'b00, wr_slot};
   endfunction

   function automatic int unsigned word_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 2;
         default: return 4;
      endcase
   endfunction

   function automatic int unsigned frame_words(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 2;
         default: return 4;
      endcase
   endfunction
endpackage

// File: rtl/cxs_ring.sv
module cxs_ring
   import cxs_pkg::*;
#(
   parameter int DW    = 17,
   parameter int PTR_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [DW-1:0]   wdata,
   input  logic            pop,
   output logic [DW-1:0]   head,
   output logic            empty,
   output logic            full,
   output logic            pop_ok,
   output logic [ST_W-1:0] status
);
   localparam int DEPTH = 1 << PTR_W;

   if (PTR_W < 1 || PTR_W > 2) begin : g_bad_ptr
      $error("cxs_ring: slot fields hold at most two bits");
   end
   if (DW < 1) begin : g_bad_dw
      $error("cxs_ring: data width must be positive");
   end

   logic [DW-1:0]  mem_q [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [PTR_W:0]   cnt_q;
   logic             err_q;
   logic             push_ok;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == (PTR_W+1)'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign head    = mem_q[rp_q];
   assign status  = pack_status(2'(wp_q), 2'(rp_q), empty, full, err_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
         err_q <= 1'b0;
      end else begin
         if (push_ok) begin
            mem_q[wp_q] <= wdata;
            wp_q        <= wp_q + 1'b1;
         end
         if (pop_ok) rp_q <= rp_q + 1'b1;
         if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
         else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
         if (push && !push_ok) err_q <= 1'b1;
      end
   end

   // R10 / R8: a refused push leaves the occupancy unchanged
   assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      push && full && !pop |=> $stable(cnt_q));
   // R8 / R10: error flag is sticky until reset
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status[10] |=> status[10]);
endmodule

// File: rtl/cxs_fifo_model.sv
module cxs_fifo_model
   import cxs_pkg::*;
#(
   parameter int LIM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_bw_we,
   input  logic [5:0]       cfg_bw,
   input  logic [LIM_W-1:0] grant,
   input  logic             per_take,
   output logic             per_avail,
   output logic [1:0]       per_pos,
   output logic [LIM_W-1:0] level
);
   if (LIM_W < 4) begin : g_bad_lim
      $error("cxs_fifo_model: level width too small for a word");
   end

   logic [5:0]       bw_q;
   logic [LIM_W-1:0] lvl_q;
   logic [1:0]       pos_q;
   logic [LIM_W-1:0] wbytes;
   logic [1:0]       last_pos;
   logic             take_ok;

   assign wbytes    = LIM_W'(word_bytes(bw_q[1:0]));
   assign last_pos  = 2'(frame_words(bw_q[5:4]) - 1);
   assign per_avail = (lvl_q >= wbytes);
   assign take_ok   = per_take && per_avail;
   assign per_pos   = pos_q;
   assign level     = lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bw_q  <= '0;
         lvl_q <= '0;
         pos_q <= '0;
      end else begin
         lvl_q <= lvl_q + grant - (take_ok ? wbytes : '0);
         if (cfg_bw_we) begin
            bw_q  <= cfg_bw;
            pos_q <= '0;
         end else if (take_ok) begin
            pos_q <= (pos_q == last_pos) ? 2'd0 : pos_q + 2'd1;
         end
      end
   end

   // R11: a refused take with no incoming data leaves the level alone
   assert_take_needs_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
      per_take && !per_avail && grant == '0 && !cfg_bw_we |=> $stable(lvl_q));
endmodule

// File: rtl/cyclic_xfer_seq.sv
module cyclic_xfer_seq
   import cxs_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int LIM_W   = 16,
   parameter int TOT_W   = 64,
   parameter int PTR_W   = 2,
   parameter int LIM_RST = 64,
   parameter int THR_RST = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             desc_push,
   input  logic [LEN_W-1:0] desc_len,
   input  logic             desc_notify,
   output logic [10:0]      sub_status,
   input  logic             cfg_bw_we,
   input  logic             cfg_fifo_we,
   input  logic [31:0]      cfg_wdata,
   output logic             mem_req,
   output logic [LIM_W-1:0] mem_bytes,
   input  logic             mem_ack,
   output logic             per_avail,
   input  logic             per_take,
   output logic [1:0]       per_pos,
   output logic [LIM_W-1:0] fifo_level,
   output logic [LEN_W-1:0] residue,
   input  logic             rpt_rd,
   output logic [31:0]      rpt_rdata,
   output logic [10:0]      rpt_status,
   output logic             desc_done
);
   localparam int W_MX = (LEN_W > LIM_W) ? LEN_W : LIM_W;
   localparam int S_DW = LEN_W + 1;
   localparam int R_DW = TOT_W + 1;

   if (LIM_W > 16 || LIM_W < 4) begin : g_bad_lim
      $error("cyclic_xfer_seq: limit field is at most 16 bits");
   end
   if (TOT_W < 32 || TOT_W > 64) begin : g_bad_tot
      $error("cyclic_xfer_seq: running total must be 32 to 64 bits");
   end

   // configuration
   logic [LIM_W-1:0] lim_q, thr_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lim_q <= LIM_W'(LIM_RST);
         thr_q <= LIM_W'(THR_RST);
      end else if (cfg_fifo_we) begin
         lim_q <= cfg_wdata[16 +: LIM_W];
         thr_q <= cfg_wdata[0 +: LIM_W];
      end
   end

   // submission ring
   logic [S_DW-1:0] sub_head;
   logic            sub_empty, sub_full, sub_pop, sub_pop_ok;
   cxs_ring #(.DW(S_DW), .PTR_W(PTR_W)) u_sub_ring (
      .clk(clk), .rst_n(rst_n),
      .push(desc_push && desc_len != '0), .wdata({desc_notify, desc_len}),
      .pop(sub_pop), .head(sub_head), .empty(sub_empty), .full(sub_full),
      .pop_ok(sub_pop_ok), .status(sub_status));

   // active descriptor and request sizing
   logic             act_q, ntf_q, done_q;
   logic [LEN_W-1:0] res_q;
   logic [TOT_W-1:0] tot_q, tot_nxt;
   logic [LIM_W-1:0] space, grant, level;
   logic [W_MX-1:0]  res_x, spc_x;
   logic             want, acked, finish;

   assign space   = (level >= lim_q) ? '0 : lim_q - level;
   assign res_x   = W_MX'(res_q);
   assign spc_x   = W_MX'(space);
   assign want    = run && act_q && (level <= thr_q) && (space != '0);
   assign mem_req = want;
   assign mem_bytes = want ? LIM_W'((res_x < spc_x) ? res_x : spc_x) : '0;
   assign acked   = want && mem_ack;
   assign grant   = acked ? mem_bytes : '0;
   assign finish  = acked && (res_x == W_MX'(mem_bytes));
   assign sub_pop = (!act_q && run) || finish;
   assign tot_nxt = tot_q + TOT_W'(grant);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         ntf_q  <= 1'b0;
         res_q  <= '0;
         tot_q  <= '0;
         done_q <= 1'b0;
      end else begin
         tot_q  <= tot_nxt;
         done_q <= finish && ntf_q;
         if (sub_pop_ok) begin
            act_q <= 1'b1;
            res_q <= sub_head[LEN_W-1:0];
            ntf_q <= sub_head[LEN_W];
         end else if (finish) begin
            act_q <= 1'b0;
            res_q <= '0;
         end else if (acked) begin
            res_q <= res_q - LEN_W'(mem_bytes);
         end
      end
   end

   assign residue   = res_q;
   assign desc_done = done_q;

   // channel FIFO occupancy and word framing
   cxs_fifo_model #(.LIM_W(LIM_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .cfg_bw_we(cfg_bw_we), .cfg_bw(cfg_wdata[5:0]),
      .grant(grant), .per_take(per_take), .per_avail(per_avail),
      .per_pos(per_pos), .level(level));
   assign fifo_level = level;

   // report ring and serial read port
   logic [R_DW-1:0] rpt_head;
   logic            rpt_empty, rpt_full, rpt_pop_ok;
   logic [1:0]      widx_q;
   logic            rd_ok;
   logic [31:0]     hi_word;

   assign rd_ok = rpt_rd && !rpt_empty;

   cxs_ring #(.DW(R_DW), .PTR_W(PTR_W)) u_rpt_ring (
      .clk(clk), .rst_n(rst_n),
      .push(finish), .wdata({ntf_q, tot_nxt}),
      .pop(rd_ok && widx_q == 2'd3), .head(rpt_head), .empty(rpt_empty),
      .full(rpt_full), .pop_ok(rpt_pop_ok), .status(rpt_status));

   if (TOT_W > 32) begin : g_hi_total
      assign hi_word = 32'(rpt_head[TOT_W-1:32]);
   end else begin : g_no_hi
      assign hi_word = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     widx_q <= '0;
      else if (rd_ok) widx_q <= widx_q + 2'd1;
   end

   always_comb begin
      rpt_rdata = '0;
      if (!rpt_empty) begin
         case (widx_q)
            2'd0:    rpt_rdata = rpt_head[31:0];
            2'd1:    rpt_rdata = hi_word;
            2'd2:    rpt_rdata = '0;
            default: rpt_rdata = {31'b0, rpt_head[TOT_W]};
         endcase
      end
   end

   // R3: requests respect threshold and limit
   assert_req_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (fifo_level <= thr_q) &&
                  ((LIM_W+1)'(fifo_level) + (LIM_W+1)'(mem_bytes) <= (LIM_W+1)'(lim_q)));
   // R4: halted channel never requests
   assert_halt_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !mem_req);
   // R1: residue steps down by the granted count
   assert_residue_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && (W_MX'(residue) != W_MX'(mem_bytes))
      |=> residue == $past(residue) - $past(LEN_W'(mem_bytes)));
   // R9: a done pulse follows an acknowledged burst
   assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      desc_done |-> $past(mem_req && mem_ack));
endmodule

// File: tb/cyclic_xfer_seq_tb_top.sv
module cyclic_xfer_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        desc_push = 1'b0;
   logic [15:0] desc_len = '0;
   logic        desc_notify = 1'b0;
   logic [10:0] sub_status;
   logic        cfg_bw_we = 1'b0;
   logic        cfg_fifo_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        mem_req;
   logic [15:0] mem_bytes;
   logic        mem_ack = 1'b0;
   logic        per_avail;
   logic        per_take = 1'b0;
   logic [1:0]  per_pos;
   logic [15:0] fifo_level;
   logic [15:0] residue;
   logic        rpt_rd = 1'b0;
   logic [31:0] rpt_rdata;
   logic [10:0] rpt_status;
   logic        desc_done;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   cyclic_xfer_seq dut_i (
      .clk(clk), .rst_n(rst_n), .run(run),
      .desc_push(desc_push), .desc_len(desc_len), .desc_notify(desc_notify),
      .sub_status(sub_status), .cfg_bw_we(cfg_bw_we), .cfg_fifo_we(cfg_fifo_we),
      .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_bytes(mem_bytes),
      .mem_ack(mem_ack), .per_avail(per_avail), .per_take(per_take),
      .per_pos(per_pos), .fifo_level(fifo_level), .residue(residue),
      .rpt_rd(rpt_rd), .rpt_rdata(rpt_rdata), .rpt_status(rpt_status),
      .desc_done(desc_done));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int wb_of(input logic [5:0] v);
      return (v[1:0] == 2'd0) ? 1 : (v[1:0] == 2'd1) ? 2 : 4;
   endfunction
   function automatic int fr_of(input logic [5:0] v);
      return (v[5:4] == 2'd0) ? 1 : (v[5:4] == 2'd1) ? 2 : 4;
   endfunction

   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic do_reset();
      run = 0; desc_push = 0; mem_ack = 0; per_take = 0; rpt_rd = 0;
      cfg_bw_we = 0; cfg_fifo_we = 0;
      rst_n = 0;
      repeat (3) nxt();
      rst_n = 1;
      nxt();
   endtask

   task automatic push_desc(input int len, input bit nf);
      desc_push = 1; desc_len = 16'(len); desc_notify = nf;
      nxt();
      desc_push = 0;
   endtask

   task automatic read_report(input logic [63:0] tot, input bit nf, input string req);
      for (int k = 0; k < 4; k++) begin
         rpt_rd = 1;
         case (k)
            0: chk(req, 64'(rpt_rdata), 64'(tot[31:0]));
            1: chk(req, 64'(rpt_rdata), 64'(tot[63:32]));
            2: chk(req, 64'(rpt_rdata), 64'd0);
            default: chk(req, 64'(rpt_rdata), 64'(nf));
         endcase
         nxt();
      end
      rpt_rd = 0;
   endtask

   // constrained-random round
   task automatic rand_round(input logic [5:0] bwv, input int ndesc);
      logic [63:0] exp_tot [0:15];
      bit          exp_nf  [0:15];
      logic [63:0] sum;
      int lim, thr, pushed, got, widx, exp_pos, cyc;
      bit prev_ack;
      logic [15:0] prev_res, prev_bytes;
      do_reset();
      cfg_bw_we = 1; cfg_wdata = 32'(bwv);
      nxt();
      cfg_bw_we = 0;
      lim = 16 + int'($urandom % 49);
      thr = int'($urandom % lim);
      cfg_fifo_we = 1; cfg_wdata = {16'(lim), 16'(thr)};
      nxt();
      cfg_fifo_we = 0;
      run = 1;
      sum = 0; pushed = 0; got = 0; widx = 0; exp_pos = 0; cyc = 0;
      prev_ack = 0; prev_res = 0; prev_bytes = 0;
      while (got < ndesc && cyc < 60000) begin
         // R1: residue step after a partial grant
         if (prev_ack && prev_res != prev_bytes)
            chk("R1 residue step", 64'(residue), 64'(prev_res - prev_bytes));
         // R3: bounds of a request and of the level
         if (mem_req) begin
            chk("R3 level at or below threshold", 64'(fifo_level <= 16'(thr)), 64'd1);
            chk("R3 burst fits limit", 64'(32'(fifo_level) + 32'(mem_bytes) <= lim), 64'd1);
         end
         chk("R11 per_avail", 64'(per_avail), 64'(int'(fifo_level) >= wb_of(bwv)));
         // R6 / R7: report words
         rpt_rd = 0;
         if (!rpt_status[8]) begin
            case (widx)
               0: chk("R7 count low", 64'(rpt_rdata), 64'(exp_tot[got][31:0]));
               1: chk("R7 count high", 64'(rpt_rdata), 64'(exp_tot[got][63:32]));
               2: chk("R6 reserved word", 64'(rpt_rdata), 64'd0);
               default: chk("R6 flags", 64'(rpt_rdata), 64'(exp_nf[got]));
            endcase
            rpt_rd = 1;
            widx++;
            if (widx == 4) begin widx = 0; got++; end
         end
         desc_push = 0;
         if (pushed < ndesc && !sub_status[9]) begin
            desc_push = 1;
            desc_len = 16'(64 + $urandom % 237);
            desc_notify = 1'($urandom);
            sum = sum + 64'(desc_len);
            exp_tot[pushed] = sum;
            exp_nf[pushed] = desc_notify;
            pushed++;
         end
         mem_ack = 1'($urandom);
         per_take = 1'($urandom);
         if (per_take && per_avail) begin
            chk("R12 per_pos", 64'(per_pos), 64'(exp_pos));
            exp_pos = (exp_pos + 1) % fr_of(bwv);
         end
         prev_ack = mem_req && mem_ack;
         prev_res = residue;
         prev_bytes = mem_bytes;
         nxt();
         cyc++;
      end
      desc_push = 0; rpt_rd = 0; mem_ack = 0; per_take = 0;
      chk("R6 all reports drained", 64'(got), 64'(ndesc));
      chk("R8 no report error", 64'(rpt_status[10]), 64'd0);
   endtask

   initial begin
      int dn;
      void'($urandom(32'd2024));
      do_reset();

      // reset state (R5, R13 defaults shown below)
      chk("R5 sub reset status", 64'(sub_status), 64'h100);
      chk("R5 rpt reset status", 64'(rpt_status), 64'h100);
      chk("R2 residue reset", 64'(residue), 64'd0);
      chk("R3 no request at reset", 64'(mem_req), 64'd0);
      chk("R9 no done at reset", 64'(desc_done), 64'd0);
      chk("R6 empty read data", 64'(rpt_rdata), 64'd0);

      // 4-byte words, 4-word frames
      cfg_bw_we = 1; cfg_wdata = 32'h22;
      nxt();
      cfg_bw_we = 0;
      push_desc(100, 1);
      chk("R5 sub after push", 64'(sub_status), 64'h001);
      nxt(); nxt();
      chk("R4 halted no load", 64'(residue), 64'd0);
      chk("R4 halted no request", 64'(mem_req), 64'd0);
      chk("R4 halted ring kept", 64'(sub_status), 64'h001);

      run = 1;
      nxt();
      chk("R2 load length", 64'(residue), 64'd100);
      chk("R5 sub after load", 64'(sub_status), 64'h111);
      chk("R3 request raised", 64'(mem_req), 64'd1);
      chk("R13 default limit caps burst", 64'(mem_bytes), 64'd64);
      mem_ack = 1;
      nxt();
      mem_ack = 0;
      chk("R1 residue after grant", 64'(residue), 64'd36);
      chk("R3 level at limit", 64'(fifo_level), 64'd64);
      chk("R13 default threshold blocks", 64'(mem_req), 64'd0);
      chk("R11 word available", 64'(per_avail), 64'd1);

      for (int i = 0; i < 9; i++) begin
         per_take = 1;
         chk("R12 frame position", 64'(per_pos), 64'(i % 4));
         if (i == 1) chk("R11 take removes word", 64'(fifo_level), 64'd60);
         nxt();
      end
      per_take = 0;
      chk("R11 level after takes", 64'(fifo_level), 64'd28);
      chk("R3 request after drain", 64'(mem_req), 64'd1);
      chk("R3 burst is residue", 64'(mem_bytes), 64'd36);

      push_desc(200, 0);
      chk("R5 sub two queued", 64'(sub_status), 64'h012);
      run = 0;
      nxt();
      chk("R4 halt drops request", 64'(mem_req), 64'd0);
      nxt(); nxt(); nxt();
      chk("R4 residue kept", 64'(residue), 64'd36);
      chk("R4 ring kept", 64'(sub_status), 64'h012);
      chk("R4 level kept", 64'(fifo_level), 64'd28);
      run = 1;
      nxt();
      chk("R4 resume request", 64'(mem_req), 64'd1);

      mem_ack = 1;
      nxt();
      mem_ack = 0;
      chk("R2 same-edge reload", 64'(residue), 64'd200);
      chk("R9 done pulse", 64'(desc_done), 64'd1);
      chk("R5 rpt one entry", 64'(rpt_status), 64'h001);
      chk("R5 sub empty after reload", 64'(sub_status), 64'h122);
      nxt();
      chk("R9 done one cycle", 64'(desc_done), 64'd0);

      read_report(64'd100, 1'b1, "R6 R7 first report");
      chk("R6 report removed", 64'(rpt_status), 64'h111);
      rpt_rd = 1;
      chk("R6 empty read zero", 64'(rpt_rdata), 64'd0);
      nxt();
      rpt_rd = 0;
      chk("R6 empty read no change", 64'(rpt_status), 64'h111);

      per_take = 1; mem_ack = 1; dn = 0;
      for (int c = 0; c < 2000 && rpt_status[8]; c++) begin
         if (desc_done) dn++;
         nxt();
      end
      per_take = 0; mem_ack = 0;
      if (desc_done) dn++;
      chk("R9 no done without notify", 64'(dn), 64'd0);
      chk("R2 idle residue", 64'(residue), 64'd0);
      read_report(64'd300, 1'b0, "R7 running total");

      // ring overflow and same-edge pop/push
      do_reset();
      push_desc(0, 1);
      chk("R10 zero length ignored", 64'(sub_status), 64'h100);
      push_desc(8, 1); push_desc(8, 0); push_desc(8, 1); push_desc(8, 0);
      push_desc(8, 1);
      chk("R10 push on full refused", 64'(sub_status), 64'h600);
      run = 1; mem_ack = 1; dn = 0;
      for (int c = 0; c < 6; c++) begin
         nxt();
         if (desc_done) dn++;
      end
      mem_ack = 0;
      chk("R9 done only with notify", 64'(dn), 64'd2);
      chk("R5 rpt full", 64'(rpt_status), 64'h200);
      chk("R1 level after four", 64'(fifo_level), 64'd32);
      chk("R2 idle after ring empty", 64'(mem_req), 64'd0);
      push_desc(8, 1);
      for (int c = 0; c < 10 && !mem_req; c++) nxt();
      chk("R3 pending burst", 64'(mem_bytes), 64'd8);
      for (int k = 0; k < 3; k++) begin
         rpt_rd = 1;
         chk("R6 head words", 64'(rpt_rdata), (k == 0) ? 64'd8 : 64'd0);
         nxt();
      end
      chk("R6 flags word", 64'(rpt_rdata), 64'd1);
      mem_ack = 1;
      nxt();
      rpt_rd = 0; mem_ack = 0;
      chk("R8 pop makes room same edge", 64'(rpt_status), 64'h211);
      chk("R9 done with concurrent read", 64'(desc_done), 64'd1);

      push_desc(8, 0);
      per_take = 1; mem_ack = 1;
      for (int c = 0; c < 50 && !rpt_status[10]; c++) nxt();
      per_take = 0; mem_ack = 0;
      chk("R8 drop sets error", 64'(rpt_status), 64'h611);
      chk("R8 stored report intact", 64'(rpt_rdata), 64'd16);

      // random rounds
      rand_round(6'h00, 10);
      rand_round(6'h11, 10);
      rand_round(6'h22, 10);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 190000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule